// File: doc/BRIEF.md
# Mirrored Record Update and Recovery Engine

This block keeps a small table of critical parameter records in two internal storage banks, a primary and a mirror. Every record holds a data word, a 16-bit CRC of that word and a change-in-progress flag. Writes have only one path, a request/acknowledge port. Each write runs an ordered sequence on the primary record and then the same sequence on the mirror record. A loss of power at any point in that sequence leaves at most one copy in doubt.

After a power-up (reset), the host pulses a scan request. The engine walks through every record and recomputes the CRC of both copies. It uses the CRC result and the change flag to decide which copy can be trusted, and rewrites the other copy from it. A record with no usable copy is set to a default value and reported. Reset clears only the control logic. The storage banks model battery-backed RAM: reset leaves them as they are, and at first power-on they hold all zeros. A read port lets the host read either bank.

Top module: `mrs_mirror_store`

## Requirements
- R1: Reset drives wr_ack, scan_busy and scan_done low and clears rep_count, lost_count and lost_mask. Reset does not change the contents of either bank.
- R2: After wr_ack, the record at wr_idx holds wr_data in both banks, with flag 0 and CRC equal to CRC-16 of the data. The CRC uses polynomial 0x1021 and seed 0xFFFF, takes the data MSB first, and applies no reflection and no final XOR.
- R3: On the primary bank, the flag is set before the new data is written. The CRC is written next, and the flag is cleared last. A power loss after the data write leaves the primary flag at 1 with the new data present.
- R4: The mirror record is not touched until the primary record holds the new data with its flag cleared. Until then the mirror keeps its old data.
- R5: The scan treats a primary copy whose stored CRC does not match its data as invalid. If the mirror copy is valid, the scan rewrites the primary from it.
- R6: The scan also treats a primary copy whose CRC matches but whose flag is 1 as invalid, and restores it from a valid mirror.
- R7: If the primary copy is valid and the mirror copy is invalid, the scan rewrites the mirror from the primary.
- R8: If both copies are valid but differ in data or CRC, the scan rewrites the mirror from the primary and counts the record as repaired.
- R9: If both copies are invalid, the scan writes DEF_VALUE with its CRC and flag 0 into both banks. It increments lost_count and sets the record's bit in lost_mask.
- R10: A scan request has priority over a write request. While scan_busy is high, wr_ack stays low, and a write request that is pending is served only after the scan ends.
- R11: scan_done is a single-cycle pulse at the end of a scan. rep_count and lost_count then hold their values until the next scan starts.
- R12: wr_ack is a single-cycle pulse, once for each accepted write.
- R13: The scan does not rewrite or count a record whose two copies are valid and identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (control logic only) |
| wr_req | input | 1 | Write request, held until wr_ack |
| wr_idx | input | IDX_W | Record index for the write |
| wr_data | input | DATA_W | New data word |
| wr_ack | output | 1 | One-cycle pulse: both copies updated |
| scan_start | input | 1 | Start a recovery scan (sampled when idle) |
| scan_busy | output | 1 | High while a scan runs |
| scan_done | output | 1 | One-cycle pulse at scan end |
| rep_count | output | CNT_W | Records repaired by the last scan |
| lost_count | output | CNT_W | Records with no valid copy in the last scan |
| lost_mask | output | DEPTH | One bit per record that fell back to default |
| rd_bank | input | 1 | Read bank select: 0 primary, 1 mirror |
| rd_idx | input | IDX_W | Read record index |
| rd_data | output | DATA_W | Stored data of the selected record |
| rd_crc | output | 16 | Stored CRC of the selected record |
| rd_flag | output | 1 | Stored change flag of the selected record |

## Verification
A write request and a scan request can reach the idle engine in the same cycle. The bench raises both on one clock edge. It then confirms that scan_busy rises and that wr_ack stays low until scan_done has pulsed, and after that it checks that the delayed write arrives intact in both banks. Power loss is modelled by pulling reset at chosen cycles inside a write. The bench first checks the bank contents that the interrupted sequence left behind, and then judges which copy the scan chose.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

   localparam int          CRC_W    = 16;
   localparam logic [15:0] CRC_POLY = 16'h1021;
   localparam logic [15:0] CRC_SEED = 16'hFFFF;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WFLAG,
      ST_WDATA,
      ST_WCRC,
      ST_WCLR,
      ST_SLOAD,
      ST_SWAIT,
      ST_SFIX,
      ST_SDONE
   } eng_state_t;

   // elaboration-time CRC of a word, MSB first
   function automatic logic [15:0] crc_of(input logic [63:0] word, input int nbits);
      logic [15:0] c;
      logic        fb;
      c = CRC_SEED;
      for (int i = nbits - 1; i >= 0; i--) begin
         fb = c[15] ^ word[i];
         c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
      end
      return c;
   endfunction

endpackage

// File: rtl/mrs_crc_serial.sv
module mrs_crc_serial
   import mrs_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic              busy,
   output logic [CRC_W-1:0]  crc
);
   localparam int CNT_W = $clog2(DATA_W + 1);

   logic [CRC_W-1:0]  crc_q;
   logic [DATA_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              fb;

   assign fb   = crc_q[CRC_W-1] ^ sh_q[DATA_W-1];
   assign busy = (cnt_q != '0);
   assign crc  = crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= CRC_SEED;
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         crc_q <= CRC_SEED;
         sh_q  <= din;
         cnt_q <= CNT_W'(DATA_W);
      end else if (busy) begin
         crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
         sh_q  <= sh_q << 1;
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // R2: the engine is never restarted in the middle of a word
   p_load_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy);

endmodule

// File: rtl/mrs_bank.sv
module mrs_bank
   import mrs_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we_flag,
   input  logic              we_data,
   input  logic              we_crc,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic              w_flag,
   input  logic [DATA_W-1:0] w_data,
   input  logic [CRC_W-1:0]  w_crc,
   input  logic [IDX_W-1:0]  ra_idx,
   output logic              ra_flag,
   output logic [DATA_W-1:0] ra_data,
   output logic [CRC_W-1:0]  ra_crc,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic              rb_flag,
   output logic [DATA_W-1:0] rb_data,
   output logic [CRC_W-1:0]  rb_crc
);
   // retained storage: no reset, all-zero power-on content
   logic              mem_flag [DEPTH] = '{default: 1'b0};
   logic [DATA_W-1:0] mem_data [DEPTH] = '{default: '0};
   logic [CRC_W-1:0]  mem_crc  [DEPTH] = '{default: '0};

   always_ff @(posedge clk) begin
      if (we_flag) mem_flag[w_idx] <= w_flag;
      if (we_data) mem_data[w_idx] <= w_data;
      if (we_crc)  mem_crc[w_idx]  <= w_crc;
   end

   assign ra_flag = mem_flag[ra_idx];
   assign ra_data = mem_data[ra_idx];
   assign ra_crc  = mem_crc[ra_idx];
   assign rb_flag = mem_flag[rb_idx];
   assign rb_data = mem_data[rb_idx];
   assign rb_crc  = mem_crc[rb_idx];

endmodule

// File: rtl/mrs_mirror_store.sv
module mrs_mirror_store
   import mrs_pkg::*;
#(
   parameter int                DATA_W    = 16,
   parameter int                DEPTH     = 8,
   parameter logic [DATA_W-1:0] DEF_VALUE = DATA_W'(16'hA5A5),
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ack,
   input  logic              scan_start,
   output logic              scan_busy,
   output logic              scan_done,
   output logic [CNT_W-1:0]  rep_count,
   output logic [CNT_W-1:0]  lost_count,
   output logic [DEPTH-1:0]  lost_mask,
   input  logic              rd_bank,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [CRC_W-1:0]  rd_crc,
   output logic              rd_flag
);
   localparam int          NBANK   = 2;
   localparam logic [15:0] DEF_CRC = crc_of(64'(DEF_VALUE), DATA_W);

   // elaboration checks
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
      $error("mrs_mirror_store: DATA_W must be 1..64");
   end
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("mrs_mirror_store: DEPTH must be a power of two, at least 2");
   end

   eng_state_t        state_q;
   logic              wsel_q;
   logic [IDX_W-1:0]  wq_idx;
   logic [DATA_W-1:0] wq_data;
   logic [IDX_W-1:0]  sc_idx;
   logic [CNT_W-1:0]  rep_q, lost_q;
   logic [DEPTH-1:0]  mask_q;
   logic              ack_q, done_q;

   logic              scan_mode, accept_wr, crc_load;
   logic [IDX_W-1:0]  int_idx;

   // per-bank wiring
   logic [NBANK-1:0]  we_f, we_d, we_c, w_flag;
   logic [DATA_W-1:0] w_data  [NBANK];
   logic [CRC_W-1:0]  w_crc   [NBANK];
   logic [NBANK-1:0]  ra_flag, rb_flag;
   logic [DATA_W-1:0] ra_data [NBANK];
   logic [DATA_W-1:0] rb_data [NBANK];
   logic [CRC_W-1:0]  ra_crc  [NBANK];
   logic [CRC_W-1:0]  rb_crc  [NBANK];
   logic [DATA_W-1:0] crc_din [NBANK];
   logic [CRC_W-1:0]  crc_val [NBANK];
   logic [NBANK-1:0]  crc_busy;

   assign scan_mode = (state_q == ST_SLOAD) || (state_q == ST_SWAIT) ||
                      (state_q == ST_SFIX)  || (state_q == ST_SDONE);
   assign accept_wr = (state_q == ST_IDLE) && !scan_start && wr_req && !ack_q;
   assign crc_load  = accept_wr || (state_q == ST_SLOAD);
   assign int_idx   = scan_mode ? sc_idx : wq_idx;

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      assign crc_din[g] = scan_mode ? ra_data[g] : wr_data;

      mrs_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_bank (
         .clk     (clk),
         .we_flag (we_f[g]),
         .we_data (we_d[g]),
         .we_crc  (we_c[g]),
         .w_idx   (int_idx),
         .w_flag  (w_flag[g]),
         .w_data  (w_data[g]),
         .w_crc   (w_crc[g]),
         .ra_idx  (int_idx),
         .ra_flag (ra_flag[g]),
         .ra_data (ra_data[g]),
         .ra_crc  (ra_crc[g]),
         .rb_idx  (rd_idx),
         .rb_flag (rb_flag[g]),
         .rb_data (rb_data[g]),
         .rb_crc  (rb_crc[g])
      );

      mrs_crc_serial #(.DATA_W(DATA_W)) i_crc (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (crc_load),
         .din   (crc_din[g]),
         .busy  (crc_busy[g]),
         .crc   (crc_val[g])
      );
   end

   // copy classification during the scan
   logic p_ok, m_ok, copies_differ;
   logic fix_to_mirror, fix_to_primary, fix_default;

   assign p_ok          = (crc_val[0] == ra_crc[0]) && !ra_flag[0];
   assign m_ok          = (crc_val[1] == ra_crc[1]) && !ra_flag[1];
   assign copies_differ = (ra_data[0] != ra_data[1]) || (ra_crc[0] != ra_crc[1]);
   assign fix_to_mirror  = p_ok && (!m_ok || copies_differ);
   assign fix_to_primary = !p_ok && m_ok;
   assign fix_default    = !p_ok && !m_ok;

   // bank write control
   always_comb begin
      we_f   = '0;
      we_d   = '0;
      we_c   = '0;
      w_flag = '0;
      for (int b = 0; b < NBANK; b++) begin
         w_data[b] = wq_data;
         w_crc[b]  = crc_val[0];
      end
      unique case (state_q)
         ST_WFLAG: begin
            we_f[wsel_q]   = 1'b1;
            w_flag[wsel_q] = 1'b1;
         end
         ST_WDATA: we_d[wsel_q] = 1'b1;
         ST_WCRC:  we_c[wsel_q] = !crc_busy[0];
         ST_WCLR:  we_f[wsel_q] = 1'b1;
         ST_SFIX: begin
            if (fix_to_mirror) begin
               we_f[1] = 1'b1; we_d[1] = 1'b1; we_c[1] = 1'b1;
               w_data[1] = ra_data[0];
               w_crc[1]  = ra_crc[0];
            end else if (fix_to_primary) begin
               we_f[0] = 1'b1; we_d[0] = 1'b1; we_c[0] = 1'b1;
               w_data[0] = ra_data[1];
               w_crc[0]  = ra_crc[1];
            end else if (fix_default) begin
               we_f = '1; we_d = '1; we_c = '1;
               for (int b = 0; b < NBANK; b++) begin
                  w_data[b] = DEF_VALUE;
                  w_crc[b]  = DEF_CRC;
               end
            end
         end
         default: ;
      endcase
   end

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wsel_q  <= 1'b0;
         wq_idx  <= '0;
         wq_data <= '0;
         sc_idx  <= '0;
         rep_q   <= '0;
         lost_q  <= '0;
         mask_q  <= '0;
         ack_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         ack_q  <= 1'b0;
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (scan_start) begin
                  sc_idx  <= '0;
                  rep_q   <= '0;
                  lost_q  <= '0;
                  mask_q  <= '0;
                  state_q <= ST_SLOAD;
               end else if (accept_wr) begin
                  wq_idx  <= wr_idx;
                  wq_data <= wr_data;
                  wsel_q  <= 1'b0;
                  state_q <= ST_WFLAG;
               end
            end
            ST_WFLAG: state_q <= ST_WDATA;
            ST_WDATA: state_q <= ST_WCRC;
            ST_WCRC:  if (!crc_busy[0]) state_q <= ST_WCLR;
            ST_WCLR: begin
               if (!wsel_q) begin
                  wsel_q  <= 1'b1;
                  state_q <= ST_WFLAG;
               end else begin
                  ack_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_SLOAD: state_q <= ST_SWAIT;
            ST_SWAIT: if (!crc_busy[0]) state_q <= ST_SFIX;
            ST_SFIX: begin
               if (fix_to_mirror || fix_to_primary) rep_q <= rep_q + 1'b1;
               if (fix_default) begin
                  lost_q         <= lost_q + 1'b1;
                  mask_q[sc_idx] <= 1'b1;
               end
               if (sc_idx == IDX_W'(DEPTH - 1)) begin
                  state_q <= ST_SDONE;
               end else begin
                  sc_idx  <= sc_idx + 1'b1;
                  state_q <= ST_SLOAD;
               end
            end
            ST_SDONE: begin
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign wr_ack     = ack_q;
   assign scan_busy  = scan_mode;
   assign scan_done  = done_q;
   assign rep_count  = rep_q;
   assign lost_count = lost_q;
   assign lost_mask  = mask_q;
   assign rd_data    = rd_bank ? rb_data[1] : rb_data[0];
   assign rd_crc     = rd_bank ? rb_crc[1]  : rb_crc[0];
   assign rd_flag    = rd_bank ? rb_flag[1] : rb_flag[0];

   // R3: data lands only on a flagged record
   p_data_after_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WDATA) |-> ra_flag[wsel_q]);
   // R3: the flag is cleared only after data and CRC are in place
   p_clear_after_crc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WCLR) |-> (ra_data[wsel_q] == wq_data) && (ra_crc[wsel_q] == crc_val[0]));
   // R4: mirror work starts only on a finished primary record
   p_mirror_after_primary_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wsel_q && !scan_mode && state_q != ST_IDLE) |-> (!ra_flag[0] && ra_data[0] == wq_data));
   // R10: no acknowledge while scanning
   p_no_ack_in_scan_r10: assert property (@(posedge clk) disable iff (!rst_n)
      scan_busy |-> !wr_ack);
   // R11: done is a single pulse
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |=> !scan_done);
   // R11: counts never exceed the record count
   p_counts_bounded_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rep_count) + int'(lost_count)) <= DEPTH);
   // R12: acknowledge is a single pulse
   p_ack_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |=> !wr_ack);

endmodule

// File: tb/test_mrs_mirror_store.sv
module test_mrs_mirror_store;
   localparam int DATA_W = 16;
   localparam int DEPTH  = 8;
   localparam int IDX_W  = $clog2(DEPTH);
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam logic [15:0] DEF = 16'hA5A5;

   localparam int K_DATA = 0, K_CRC = 1, K_FLAG = 2, K_REP = 3, K_LOST = 4, K_MASK = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_req = 1'b0;
   logic [IDX_W-1:0]  wr_idx = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              wr_ack;
   logic              scan_start = 1'b0;
   logic              scan_busy, scan_done;
   logic [CNT_W-1:0]  rep_count, lost_count;
   logic [DEPTH-1:0]  lost_mask;
   logic              rd_bank = 1'b0;
   logic [IDX_W-1:0]  rd_idx = '0;
   logic [DATA_W-1:0] rd_data;
   logic [15:0]       rd_crc;
   logic              rd_flag;

   always #4 clk = ~clk;

   mrs_mirror_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DEF_VALUE(DEF)) i_mrs_mirror_store (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(wr_data),
      .wr_ack(wr_ack), .scan_start(scan_start), .scan_busy(scan_busy), .scan_done(scan_done),
      .rep_count(rep_count), .lost_count(lost_count), .lost_mask(lost_mask),
      .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data), .rd_crc(rd_crc), .rd_flag(rd_flag)
   );

   int n_cmp = 0;
   int n_bad = 0;
   logic [15:0] model [DEPTH];

   function automatic logic [15:0] ref_crc(input logic [15:0] d);
      logic [15:0] r = 16'hFFFF;
      for (int i = 15; i >= 0; i--) begin
         if (r[15] != d[i]) r = (r << 1) ^ 16'h1021;
         else               r = r << 1;
      end
      return r;
   endfunction

   task automatic tally(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard
   typedef struct {
      int          kind;
      int          bank;
      int          idx;
      logic [31:0] exp;
      string       req;
   } item_t;
   item_t sb_q[$];
   bit    mon_busy = 1'b0;

   always begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         mon_busy = 1'b1;
         it = sb_q.pop_front();
         rd_bank = it.bank[0];
         rd_idx  = IDX_W'(it.idx);
         #1;
         case (it.kind)
            K_DATA:  act = 32'(rd_data);
            K_CRC:   act = 32'(rd_crc);
            K_FLAG:  act = 32'(rd_flag);
            K_REP:   act = 32'(rep_count);
            K_LOST:  act = 32'(lost_count);
            default: act = 32'(lost_mask);
         endcase
         tally(act == it.exp, it.req, act, it.exp);
         mon_busy = 1'b0;
      end
   end

   task automatic push(input int kind, input int bank, input int idx, input logic [31:0] exp, input string req);
      item_t it;
      it.kind = kind; it.bank = bank; it.idx = idx; it.exp = exp; it.req = req;
      sb_q.push_back(it);
   endtask

   task automatic drain();
      while (sb_q.size() != 0 || mon_busy) @(posedge clk);
   endtask

   task automatic expect_rec(input int bank, input int idx, input logic [15:0] d, input string req);
      push(K_DATA, bank, idx, 32'(d), req);
      push(K_CRC,  bank, idx, 32'(ref_crc(d)), req);
      push(K_FLAG, bank, idx, 32'd0, req);
   endtask

   task automatic expect_both(input int idx, input logic [15:0] d, input string req);
      expect_rec(0, idx, d, req);
      expect_rec(1, idx, d, req);
   endtask

   task automatic expect_counts(input int rep, input int lost, input logic [DEPTH-1:0] mask, input string req);
      push(K_REP,  0, 0, 32'(rep), req);
      push(K_LOST, 0, 0, 32'(lost), req);
      push(K_MASK, 0, 0, 32'(mask), req);
   endtask

   task automatic power_cycle();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_write(input int idx, input logic [15:0] d);
      int guard = 0;
      @(negedge clk);
      wr_req = 1'b1; wr_idx = IDX_W'(idx); wr_data = d;
      do begin
         @(negedge clk);
         guard++;
      end while (!wr_ack && guard < 200);
      wr_req = 1'b0;
      model[idx] = d;
      @(negedge clk);
      tally(wr_ack == 1'b0, "R12 ack width", 32'(wr_ack), 32'd0);
   endtask

   // power loss after k clock edges past the accepting edge
   task automatic fail_write(input int idx, input logic [15:0] d, input int k);
      @(negedge clk);
      wr_req = 1'b1; wr_idx = IDX_W'(idx); wr_data = d;
      @(posedge clk);
      repeat (k) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      wr_req = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_scan();
      int guard = 0;
      @(negedge clk);
      scan_start = 1'b1;
      @(negedge clk);
      scan_start = 1'b0;
      while (!scan_done && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
      tally(scan_done == 1'b0, "R11 done width", 32'(scan_done), 32'd0);
   endtask

   function automatic logic [15:0] val_of(input int i);
      return 16'(i * 16'h1357 + 16'h0246);
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      tally(wr_ack == 1'b0 && scan_busy == 1'b0 && scan_done == 1'b0, "R1 flags", 32'({wr_ack, scan_busy, scan_done}), 32'd0);
      rst_n = 1'b1;
      expect_counts(0, 0, '0, "R1 counts");
      drain();

      // R9: cold RAM, nothing valid
      do_scan();
      expect_counts(0, DEPTH, '1, "R9 cold scan");
      expect_both(0, DEF, "R9 default idx0");
      expect_both(DEPTH - 1, DEF, "R9 default last");
      drain();
      repeat (5) @(negedge clk);
      expect_counts(0, DEPTH, '1, "R11 counts hold");
      drain();

      // R2: fill the table
      for (int i = 0; i < DEPTH; i++) do_write(i, val_of(i));
      expect_both(1, model[1], "R2 idx1");
      expect_both(6, model[6], "R2 idx6");
      drain();

      // R13: intact table, no repairs
      do_scan();
      expect_counts(0, 0, '0, "R13 clean scan");
      drain();

      // R1: storage survives reset
      power_cycle();
      expect_both(7, model[7], "R1 RAM kept");
      expect_counts(0, 0, '0, "R1 counts cleared");
      drain();

      // R5: loss after primary data write (stale CRC)
      fail_write(2, 16'hBEEF, 2);
      push(K_FLAG, 0, 2, 32'd1, "R3 flag set before data");
      push(K_DATA, 0, 2, 32'hBEEF, "R3 data after flag");
      push(K_DATA, 1, 2, 32'(model[2]), "R4 mirror untouched");
      drain();
      do_scan();
      expect_counts(1, 0, '0, "R5 counts");
      expect_both(2, model[2], "R5 restore primary");
      expect_both(0, model[0], "R13 other record");
      drain();

      // R6: loss after primary CRC write, flag still set
      fail_write(3, 16'h1DEA, 17);
      push(K_CRC,  0, 3, 32'(ref_crc(16'h1DEA)), "R3 CRC before clear");
      push(K_FLAG, 0, 3, 32'd1, "R3 flag still set");
      drain();
      do_scan();
      expect_counts(1, 0, '0, "R6 counts");
      expect_both(3, model[3], "R6 restore flagged primary");
      drain();

      // R7: loss after mirror flag set
      fail_write(4, 16'hC0DE, 19);
      push(K_FLAG, 1, 4, 32'd1, "R4 mirror flag");
      push(K_DATA, 1, 4, 32'(model[4]), "R4 mirror old data");
      drain();
      model[4] = 16'hC0DE;
      do_scan();
      expect_counts(1, 0, '0, "R7 counts");
      expect_both(4, model[4], "R7 mirror rebuilt");
      drain();

      // R8: loss between the two copies
      fail_write(5, 16'h7777, 18);
      push(K_FLAG, 1, 5, 32'd0, "R8 mirror clean before scan");
      push(K_DATA, 1, 5, 32'(model[5]), "R8 mirror old before scan");
      drain();
      model[5] = 16'h7777;
      do_scan();
      expect_counts(1, 0, '0, "R8 counts");
      expect_both(5, model[5], "R8 mirror follows primary");
      drain();

      // R10: write and scan requested in the same cycle
      begin
         bit seen_done = 1'b0;
         bit early_ack = 1'b0;
         int guard = 0;
         @(negedge clk);
         wr_req = 1'b1; wr_idx = IDX_W'(6); wr_data = 16'h4242; scan_start = 1'b1;
         @(negedge clk);
         scan_start = 1'b0;
         tally(scan_busy == 1'b1, "R10 scan wins", 32'(scan_busy), 32'd1);
         while (!wr_ack && guard < 1000) begin
            @(negedge clk);
            if (scan_done) seen_done = 1'b1;
            if (wr_ack && !seen_done) early_ack = 1'b1;
            guard++;
         end
         wr_req = 1'b0;
         model[6] = 16'h4242;
         tally(!early_ack && seen_done, "R10 ack after scan", 32'({early_ack, seen_done}), 32'b01);
         expect_both(6, model[6], "R10 delayed write");
         expect_counts(0, 0, '0, "R10 scan result");
         drain();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule